// File: doc/BRIEF.md
# Configurable TDM/I2S Frame Serializer

This block is a master-mode serial audio transmitter. It divides its master clock into a bit clock, generates the frame sync, and shifts parallel sample words out one bit per bit clock into time slots. A frame consists of a programmable number of slots, each a programmable number of bits wide. Mono streams still use a frame of two slots, with the unused slot masked.

I2S, left-justified, DSP-A and DSP-B framing are all produced from the same few settings. The sync width is one slot for I2S and left-justified, and one bit for the DSP formats. The sync-early option asserts sync one bit before slot 0; I2S and DSP-A use it. The sync is active low for I2S and active high for the other formats. A bit-clock inversion option selects which edge launches data.

Each unmasked slot takes one word from a valid/ready input. A masked slot releases the data line and takes no word. If no word is offered when an unmasked slot begins, the slot carries zeros and an underrun pulse is raised. Configuration inputs are expected to change only while `enable` is low.

Top module: `tdm_frame_serializer`

## Requirements
- R1: The bit clock period is 2*(cfg_div+1) master clock cycles, high for cfg_div+1 and low for cfg_div+1, so the ratio covers every even value from 2 to 512 with an 8-bit field.
- R2: A frame is cfg_slots*cfg_slot_width bits long. With cfg_sync_early=0 the sync is active from bit 0 of slot 0 for cfg_sync_width bits.
- R3: With cfg_sync_early=1 the whole sync window moves one bit earlier, so it starts on the last bit of the previous frame.
- R4: fsync_o is active low when cfg_sync_low=1 and active high otherwise. With cfg_bclk_inv=0 data changes on falling bclk_o edges; with cfg_bclk_inv=1 it changes on rising edges.
- R5: With cfg_lsb_first=0, bit b of a slot (b=0 first) carries word[cfg_first_bit-b], or 0 when that index is negative.
- R6: With cfg_lsb_first=1, bit b carries word[cfg_first_bit+b], or 0 when that index is at or above the word width.
- R7: A set cfg_mask[s] makes slot s masked: sdata_oe_o stays 0, sdata_o stays 0 and no word is requested. Bits at and above cfg_slots must be set.
- R8: in_ready is high for exactly one master clock cycle, ending at the edge that launches bit 0 of an unmasked slot, and the word is taken at that edge when in_valid is high.
- R9: If in_valid is low at that edge, the slot sends all zeros and underrun_o is high for the one following cycle.
- R10: While enable is low, bclk_o rests at cfg_bclk_inv, fsync_o at its inactive level, sdata_o and sdata_oe_o at 0, and in_ready at 0. Raising enable starts a new frame at slot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the transmitter; low forces the idle state |
| cfg_div | input | DIV_W | Half the bit-clock ratio minus one |
| cfg_slots | input | $clog2(MAX_SLOTS+1) | Slots per frame (1..MAX_SLOTS) |
| cfg_slot_width | input | $clog2(DATA_W+1) | Bits per slot (1..DATA_W) |
| cfg_sync_width | input | $clog2(DATA_W+1) | Sync width in bit clocks |
| cfg_first_bit | input | $clog2(DATA_W) | Word bit index sent first |
| cfg_sync_early | input | 1 | Sync leads the frame by one bit |
| cfg_sync_low | input | 1 | Sync is active low |
| cfg_bclk_inv | input | 1 | Inverts the bit clock output |
| cfg_lsb_first | input | 1 | Walks the word upward instead of downward |
| cfg_mask | input | MAX_SLOTS | One bit per slot; set disables the slot |
| in_valid | input | 1 | Sample word offered |
| in_data | input | DATA_W | Sample word |
| in_ready | output | 1 | Word taken at this edge if in_valid |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| sdata_oe_o | output | 1 | Data line drive enable |
| underrun_o | output | 1 | One-cycle pulse for a slot that had no word |

## Verification
bclk_o, fsync_o, sdata_o, sdata_oe_o and underrun_o are registered on the master clock edge that launches a bit, so they are due in the cycle after that edge. in_ready is combinational and is valid during the cycle before the launch edge. The bench samples on the falling master clock edge. It recognises a launch by a high-to-low change of the raw bit clock (bclk_o with cfg_bclk_inv removed). It checks the bit it models at that moment, and it captures the offered word in the cycle where in_ready is seen, before the launch edge. The bit-clock period is measured in master cycles between consecutive launches.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  // Index of the word bit carried at bit position bit_pos of a slot, -1 when none.
  function automatic int src_index(int first_bit, int bit_pos, bit lsb_first, int data_w);
    int idx;
    if (lsb_first) begin
      idx = first_bit + bit_pos;
      return (idx < data_w) ? idx : -1;
    end
    idx = first_bit - bit_pos;
    return (idx >= 0) ? idx : -1;
  endfunction

  // Sync level (active = 1) for frame bit position pos.
  function automatic bit sync_on(int pos, int frame_len, int sync_w, bit early);
    int lead;
    if (early) lead = (pos + 1 >= frame_len) ? 0 : pos + 1;
    else       lead = pos;
    return lead < sync_w;
  endfunction

endpackage

// File: rtl/tfs_bclk_div.sv
module tfs_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_raw,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == div);
  // launch edge: raw clock about to fall
  assign tick   = run && at_end && bclk_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bclk_raw <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      bclk_raw <= 1'b0;
    end else if (at_end) begin
      cnt      <= '0;
      bclk_raw <= ~bclk_raw;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tfs_frame_seq.sv
module tfs_frame_seq #(
  parameter int MAX_SLOTS = 8,
  parameter int SLOT_CW   = 4,
  parameter int BIT_CW    = 6,
  parameter int POS_W     = 9,
  parameter int SIW       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic [SLOT_CW-1:0]   cfg_slots,
  input  logic [BIT_CW-1:0]    cfg_slot_width,
  input  logic [MAX_SLOTS-1:0] cfg_mask,
  output logic [SIW-1:0]       nxt_slot,
  output logic [BIT_CW-1:0]    nxt_bit,
  output logic [POS_W-1:0]     nxt_pos,
  output logic                 nxt_masked,
  output logic                 slot_start
);
  logic [SIW-1:0]    cur_slot;
  logic [BIT_CW-1:0] cur_bit;
  logic [POS_W-1:0]  cur_pos;
  logic              started;
  logic              last_bit, last_slot;

  always_comb begin
    last_bit  = (cur_bit == cfg_slot_width - BIT_CW'(1));
    last_slot = (SLOT_CW'(cur_slot) == cfg_slots - SLOT_CW'(1));
    if (!started) begin
      nxt_slot = '0;
      nxt_bit  = '0;
      nxt_pos  = '0;
    end else if (last_bit) begin
      nxt_bit  = '0;
      nxt_slot = last_slot ? '0 : cur_slot + 1'b1;
      nxt_pos  = last_slot ? '0 : cur_pos + 1'b1;
    end else begin
      nxt_bit  = cur_bit + 1'b1;
      nxt_slot = cur_slot;
      nxt_pos  = cur_pos + 1'b1;
    end
    nxt_masked = cfg_mask[nxt_slot];
    slot_start = (nxt_bit == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot <= '0;
      cur_bit  <= '0;
      cur_pos  <= '0;
      started  <= 1'b0;
    end else if (!run) begin
      cur_slot <= '0;
      cur_bit  <= '0;
      cur_pos  <= '0;
      started  <= 1'b0;
    end else if (tick) begin
      cur_slot <= nxt_slot;
      cur_bit  <= nxt_bit;
      cur_pos  <= nxt_pos;
      started  <= 1'b1;
    end
  end
endmodule

// File: rtl/tfs_slot_shifter.sv
module tfs_slot_shifter #(
  parameter int DATA_W = 32,
  parameter int BIT_CW = 6,
  parameter int POS_W  = 9,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              slot_start,
  input  logic              nxt_masked,
  input  logic [BIT_CW-1:0] nxt_bit,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic [POS_W-1:0]  frame_len,
  input  logic [BIT_CW-1:0] cfg_sync_width,
  input  logic [IDX_W-1:0]  cfg_first_bit,
  input  logic              cfg_sync_early,
  input  logic              cfg_lsb_first,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              sync_act,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              underrun
);
  logic [DATA_W-1:0] word_q, fresh, word_src;
  logic              fetch, bit_val, sync_next;
  int                idx;

  assign fetch    = tick && slot_start && !nxt_masked;
  assign in_ready = fetch;
  assign fresh    = in_valid ? in_data : '0;
  assign word_src = slot_start ? fresh : word_q;

  always_comb begin
    idx       = tfs_pkg::src_index(int'(cfg_first_bit), int'(nxt_bit), cfg_lsb_first, DATA_W);
    bit_val   = (idx >= 0) ? word_src[idx[IDX_W-1:0]] : 1'b0;
    sync_next = tfs_pkg::sync_on(int'(nxt_pos), int'(frame_len), int'(cfg_sync_width),
                                 cfg_sync_early);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0; sync_act <= 1'b0; sdata <= 1'b0; sdata_oe <= 1'b0; underrun <= 1'b0;
    end else if (!run) begin
      word_q <= '0; sync_act <= 1'b0; sdata <= 1'b0; sdata_oe <= 1'b0; underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (tick) begin
        sync_act <= sync_next;
        sdata_oe <= !nxt_masked;
        sdata    <= !nxt_masked && bit_val;
        if (fetch) begin
          word_q   <= fresh;
          underrun <= !in_valid;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer #(
  parameter int DATA_W    = 32,
  parameter int MAX_SLOTS = 8,
  parameter int DIV_W     = 8,
  localparam int SLOT_CW  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_CW   = $clog2(DATA_W + 1),
  localparam int IDX_W    = $clog2(DATA_W),
  localparam int SIW      = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int POS_W    = $clog2(MAX_SLOTS * DATA_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [SLOT_CW-1:0]   cfg_slots,
  input  logic [BIT_CW-1:0]    cfg_slot_width,
  input  logic [BIT_CW-1:0]    cfg_sync_width,
  input  logic [IDX_W-1:0]     cfg_first_bit,
  input  logic                 cfg_sync_early,
  input  logic                 cfg_sync_low,
  input  logic                 cfg_bclk_inv,
  input  logic                 cfg_lsb_first,
  input  logic [MAX_SLOTS-1:0] cfg_mask,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 in_ready,
  output logic                 bclk_o,
  output logic                 fsync_o,
  output logic                 sdata_o,
  output logic                 sdata_oe_o,
  output logic                 underrun_o
);
  // named internal events (also observed by the checker)
  logic              bit_tick;
  logic              slot_start;
  logic              bclk_raw;
  logic              sync_act;
  logic              nxt_masked;
  logic [SIW-1:0]    nxt_slot;
  logic [BIT_CW-1:0] nxt_bit;
  logic [POS_W-1:0]  nxt_pos;
  logic [POS_W-1:0]  frame_len;

  assign frame_len = POS_W'(cfg_slots) * POS_W'(cfg_slot_width);

  tfs_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(enable), .div(cfg_div),
    .bclk_raw(bclk_raw), .tick(bit_tick)
  );

  tfs_frame_seq #(
    .MAX_SLOTS(MAX_SLOTS), .SLOT_CW(SLOT_CW), .BIT_CW(BIT_CW), .POS_W(POS_W), .SIW(SIW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(bit_tick),
    .cfg_slots(cfg_slots), .cfg_slot_width(cfg_slot_width), .cfg_mask(cfg_mask),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_pos(nxt_pos),
    .nxt_masked(nxt_masked), .slot_start(slot_start)
  );

  tfs_slot_shifter #(
    .DATA_W(DATA_W), .BIT_CW(BIT_CW), .POS_W(POS_W), .IDX_W(IDX_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(bit_tick),
    .slot_start(slot_start), .nxt_masked(nxt_masked), .nxt_bit(nxt_bit),
    .nxt_pos(nxt_pos), .frame_len(frame_len), .cfg_sync_width(cfg_sync_width),
    .cfg_first_bit(cfg_first_bit), .cfg_sync_early(cfg_sync_early),
    .cfg_lsb_first(cfg_lsb_first), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sync_act(sync_act), .sdata(sdata_o),
    .sdata_oe(sdata_oe_o), .underrun(underrun_o)
  );

  assign bclk_o  = bclk_raw ^ cfg_bclk_inv;
  assign fsync_o = sync_act ^ cfg_sync_low;

  // nxt_slot is consumed inside the sequencer for mask lookup
  logic unused_slot;
  assign unused_slot = ^nxt_slot;
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bit_tick,
  input logic in_ready,
  input logic in_valid,
  input logic fsync_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic underrun_o
);
  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  // R9
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> $past(in_ready && !in_valid));

  // R9
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe_o |-> !sdata_o);

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !in_ready);

  // R8
  fetch_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> sdata_oe_o);

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable && !$past(bit_tick)) |->
      ($stable(fsync_o) && $stable(sdata_o) && $stable(sdata_oe_o)));
endmodule

bind tdm_frame_serializer tfs_checker u_chk (.*);

// File: tb/tb_tdm_frame_serializer.sv
module tb_tdm_frame_serializer;
  localparam int DATA_W = 32, MAX_SLOTS = 8, DIV_W = 8;
  localparam int SLOT_CW = $clog2(MAX_SLOTS + 1);
  localparam int BIT_CW  = $clog2(DATA_W + 1);
  localparam int IDX_W   = $clog2(DATA_W);

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [SLOT_CW-1:0] cfg_slots = '0;
  logic [BIT_CW-1:0] cfg_slot_width = '0, cfg_sync_width = '0;
  logic [IDX_W-1:0] cfg_first_bit = '0;
  logic cfg_sync_early = 0, cfg_sync_low = 0, cfg_bclk_inv = 0, cfg_lsb_first = 0;
  logic [MAX_SLOTS-1:0] cfg_mask = '0;
  logic in_valid = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, bclk_o, fsync_o, sdata_o, sdata_oe_o, underrun_o;

  tdm_frame_serializer #(.DATA_W(DATA_W), .MAX_SLOTS(MAX_SLOTS), .DIV_W(DIV_W)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // configuration mirror
  int c_slots, c_w, c_sw, c_first, c_early, c_low, c_inv, c_lsb, c_mask, c_div, c_vpct;
  // model state
  bit monitor_on = 0, m_started, prev_raw, have_tick, rdy_seen, snap_under;
  int m_slot, m_bit, m_pos, frames, since_tick;
  logic [DATA_W-1:0] m_word, snap_word;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(logic [DATA_W-1:0] w, int b);
    if (c_lsb != 0) return (c_first + b < DATA_W) ? w[c_first + b] : 1'b0;
    return (b <= c_first) ? w[c_first - b] : 1'b0;
  endfunction

  function automatic bit exp_sync(int p);
    int len = c_slots * c_w;
    int q = p;
    if (c_early != 0) q = (p == len - 1) ? 0 : p + 1;
    return q < c_sw;
  endfunction

  always @(negedge clk) begin
    if (monitor_on) begin
      bit raw, masked, startu, e;
      raw = bclk_o ^ c_inv[0];
      since_tick++;
      if (prev_raw && !raw) begin
        // R1: period between launches
        if (have_tick) chk(since_tick == 2 * (c_div + 1), "R1", "bclk period", since_tick, 2 * (c_div + 1));
        have_tick = 1; since_tick = 0;
        if (!m_started) begin
          m_started = 1; m_slot = 0; m_bit = 0; m_pos = 0;
        end else begin
          m_bit++; m_pos++;
          if (m_bit == c_w) begin
            m_bit = 0; m_slot++;
            if (m_slot == c_slots) begin m_slot = 0; m_pos = 0; frames++; end
          end
        end
        masked = c_mask[m_slot];
        startu = (m_bit == 0) && !masked;
        chk(rdy_seen == startu, "R8", "ready before slot start", rdy_seen, startu);
        if (startu) m_word = snap_word;
        chk(sdata_oe_o == !masked, "R7", "drive enable", sdata_oe_o, !masked);
        e = exp_sync(m_pos) ^ c_low[0];
        chk(fsync_o == e, (c_early != 0) ? "R3" : "R2", "frame sync", fsync_o, e);
        e = masked ? 1'b0 : exp_bit(m_word, m_bit);
        chk(sdata_o == e, (c_lsb != 0) ? "R6" : "R5", "serial bit", sdata_o, e);
        chk(underrun_o == (startu && snap_under), "R9", "underrun at slot", underrun_o, startu && snap_under);
        rdy_seen = 0;
      end else begin
        chk(underrun_o == 1'b0, "R9", "underrun off-slot", underrun_o, 0);
      end
      prev_raw = raw;
      in_valid = ($urandom_range(99) < c_vpct);
      in_data  = $urandom();
      if (in_ready) begin
        chk(!rdy_seen, "R8", "single ready per slot", rdy_seen, 0);
        rdy_seen   = 1;
        snap_word  = in_valid ? in_data : '0;
        snap_under = !in_valid;
      end
    end
  end

  task automatic run_cfg(int slots, int w, int sw, int first, int early, int low, int inv,
                         int lsb, int mask, int div, int vpct, int nfr);
    @(negedge clk);
    monitor_on = 0; enable = 0; in_valid = 0;
    c_slots = slots; c_w = w; c_sw = sw; c_first = first; c_early = early; c_low = low;
    c_inv = inv; c_lsb = lsb; c_div = div; c_vpct = vpct;
    c_mask = mask | ((1 << MAX_SLOTS) - (1 << slots));
    cfg_slots = SLOT_CW'(slots); cfg_slot_width = BIT_CW'(w); cfg_sync_width = BIT_CW'(sw);
    cfg_first_bit = IDX_W'(first); cfg_sync_early = early[0]; cfg_sync_low = low[0];
    cfg_bclk_inv = inv[0]; cfg_lsb_first = lsb[0]; cfg_mask = MAX_SLOTS'(c_mask);
    cfg_div = DIV_W'(div);
    repeat (3) @(negedge clk);
    // R10: idle levels while disabled
    chk(bclk_o == inv[0], "R10", "idle bclk", bclk_o, inv);
    chk(fsync_o == low[0], "R10", "idle sync", fsync_o, low);
    chk(sdata_oe_o == 0 && sdata_o == 0, "R10", "idle data", sdata_oe_o, 0);
    chk(in_ready == 0, "R10", "idle ready", in_ready, 0);
    m_started = 0; prev_raw = 0; have_tick = 0; rdy_seen = 0; snap_under = 0;
    frames = 0; since_tick = 0; m_word = '0; snap_word = '0;
    monitor_on = 1; enable = 1;
    wait (frames >= nfr);
    @(negedge clk);
    monitor_on = 0; enable = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(bclk_o == 0 && fsync_o == 0 && sdata_oe_o == 0, "R10", "reset outputs", bclk_o, 0);
    chk(in_ready == 0 && underrun_o == 0, "R10", "reset handshake", in_ready, 0);
    rst_n = 1;
    // I2S: two 16-bit slots, early, active-low sync, slot-wide sync
    run_cfg(2, 16, 16, 15, 1, 1, 0, 0, 0, 1, 100, 3);
    // left-justified
    run_cfg(2, 16, 16, 15, 0, 0, 0, 0, 0, 1, 100, 3);
    // DSP-A, slots 1 and 3 masked, minimum ratio
    run_cfg(4, 8, 1, 7, 1, 0, 0, 0, 'b1010, 0, 100, 3);
    // DSP-B, eight full-width slots, inverted bit clock (R4)
    run_cfg(8, 32, 1, 31, 0, 0, 1, 0, 0, 1, 100, 2);
    // R6: LSB-first, running past the top of the word
    run_cfg(3, 8, 1, 28, 0, 0, 0, 1, 0, 2, 100, 3);
    // R5: MSB-first, running below bit zero
    run_cfg(3, 8, 8, 3, 1, 1, 1, 0, 0, 0, 100, 3);
    // mono in two slots, second masked
    run_cfg(2, 24, 24, 23, 1, 1, 0, 0, 'b10, 1, 100, 3);
    // R9: starved input
    run_cfg(4, 6, 2, 5, 0, 0, 0, 0, 'b0100, 0, 40, 4);
    // R1: maximum ratio 512
    run_cfg(2, 4, 1, 3, 0, 0, 0, 0, 0, 255, 100, 1);
    for (int i = 0; i < 10; i++) begin
      int s = $urandom_range(MAX_SLOTS, 2);
      int w = $urandom_range(32, 4);
      run_cfg(s, w, $urandom_range(w, 1), $urandom_range(31, 0), $urandom_range(1, 0),
              $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0),
              $urandom_range(255, 0) & ((1 << s) - 2), $urandom_range(3, 0),
              $urandom_range(100, 50), 2);
    end
    finish_run();
  end
endmodule